// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block sits at the front of a slave-side I2C interface and watches the SCL and SDA lines for the framing conditions that delimit transfers. Each raw line passes through a two-flop synchronizer and a three-sample majority filter. Edge detection runs on the filtered copies. The block reports a Start seen on an idle bus, a Repeated Start seen on an active bus, and a Stop. Each event is a one-clock pulse. A bus-active flag follows the framing.

A Stop is only accepted when SCL has been low at least once since the last Start. An SDA fall and rise with SCL held high the whole time therefore yields a Start and nothing more. Any Start or Repeated Start also pulses a clear strobe, so that the receive logic treats the next byte as an address.

An interrupt pulse can follow a framing event. Two enables allow it separately for Start-type events and for Stop. A mode input tells the block that the surrounding slave mode already interrupts on these events. While that input is high, the interrupt is raised regardless of the enables.

Top module: `i2c_cond_det`

## Requirements
- R1: While reset is asserted and on the first cycle after it, start_o, rstart_o, stop_o, rx_clr_o, irq_o and bus_active_o are all 0.
- R2: A falling SDA with SCL high while the bus is idle gives exactly one start_o pulse and sets bus_active_o to 1.
- R3: A rising SDA with SCL high, on an active bus where SCL has been low since the last Start, gives exactly one stop_o pulse and returns bus_active_o to 0.
- R4: A rising SDA with SCL high when SCL has not been low since the last Start gives no event, and bus_active_o stays 1.
- R5: A falling SDA with SCL high, on an active bus where SCL has been low since the last Start, gives one rstart_o pulse and no start_o pulse, and bus_active_o stays 1.
- R6: SDA edges while SCL is low produce no event. An SDA edge landing in the same sample as an SCL edge also produces no event.
- R7: A one-clock pulse on SDA is filtered out and produces no event. A level held for 3 or more clocks is accepted.
- R8: After reset is released with either line low, no event is reported until both lines have been seen high.
- R9: rx_clr_o pulses in the same cycle as every start_o or rstart_o pulse, and at no other time.
- R10: irq_o pulses one cycle after a start_o or rstart_o pulse when start_ie_i or mode_irq_i is 1. It pulses one cycle after a stop_o pulse when stop_ie_i or mode_irq_i is 1. It is never high otherwise.
- R11: Each event pulse is one clock wide, and at most one of start_o, rstart_o and stop_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| mode_irq_i | input | 1 | Slave mode already interrupts on Start/Stop |
| start_ie_i | input | 1 | Allow interrupt on Start and Repeated Start |
| stop_ie_i | input | 1 | Allow interrupt on Stop |
| start_o | output | 1 | Start on idle bus, one-cycle pulse |
| rstart_o | output | 1 | Repeated Start, one-cycle pulse |
| stop_o | output | 1 | Stop, one-cycle pulse |
| rx_clr_o | output | 1 | Receive-logic clear strobe |
| bus_active_o | output | 1 | Bus is between Start and Stop |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The two functions that can meet in one sample are SCL edge tracking and SDA edge classification. They collide when both lines change on the same clock. The bench provokes this on an active bus, first with both lines falling together and then with both rising together. In each case it checks that no Repeated Start and no Stop are counted and that bus_active_o stays high. A properly separated Stop then closes the frame and confirms that the state was not disturbed.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
  } cond_ev_t;

  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_SCL  = 0;
  localparam int unsigned LINE_SDA  = 1;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WIN         = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned HALF = WIN / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [WIN-1:0]         win_q;
  logic                   filt_q;

  // reset low: nothing counts as "seen high" until real samples arrive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      win_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
      filt_q <= ($countones(win_q) > HALF);
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
  import i2c_cond_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_f_i,
  input  logic     sda_f_i,
  output cond_ev_t ev_o,
  output logic     active_o
);
  logic     scl_q, sda_q, armed_q, active_q, low_seen_q;
  cond_ev_t ev_d, ev_q;
  logic     hi_hold, start_edge, stop_edge;

  always_comb begin
    hi_hold    = scl_f_i & scl_q;
    start_edge = armed_q & hi_hold & sda_q & ~sda_f_i;
    stop_edge  = armed_q & hi_hold & ~sda_q & sda_f_i;
    ev_d.start  = start_edge & ~active_q;
    ev_d.rstart = start_edge & active_q & low_seen_q;
    ev_d.stop   = stop_edge & active_q & low_seen_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q      <= 1'b0;
      sda_q      <= 1'b0;
      armed_q    <= 1'b0;
      active_q   <= 1'b0;
      low_seen_q <= 1'b0;
      ev_q       <= '0;
    end else begin
      scl_q   <= scl_f_i;
      sda_q   <= sda_f_i;
      armed_q <= armed_q | (scl_f_i & sda_f_i);
      ev_q    <= ev_d;
      if (ev_d.start)     active_q <= 1'b1;
      else if (ev_d.stop) active_q <= 1'b0;
      if (ev_d.start | ev_d.rstart | ev_d.stop) low_seen_q <= 1'b0;
      else if (active_q & ~scl_f_i)             low_seen_q <= 1'b1;
    end
  end

  assign ev_o     = ev_q;
  assign active_o = active_q;
endmodule

// File: rtl/i2c_cond_irq.sv
module i2c_cond_irq
  import i2c_cond_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cond_ev_t ev_i,
  input  logic     mode_irq_i,
  input  logic     start_ie_i,
  input  logic     stop_ie_i,
  output logic     irq_o
);
  logic irq_q, start_req, stop_req;

  // slave mode with native start/stop interrupts overrides the enables
  assign start_req = (ev_i.start | ev_i.rstart) & (mode_irq_i | start_ie_i);
  assign stop_req  = ev_i.stop & (mode_irq_i | stop_ie_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= start_req | stop_req;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det
  import i2c_cond_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_WIN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic mode_irq_i,
  input  logic start_ie_i,
  input  logic stop_ie_i,
  output logic start_o,
  output logic rstart_o,
  output logic stop_o,
  output logic rx_clr_o,
  output logic bus_active_o,
  output logic irq_o
);
  logic [NUM_LINES-1:0] raw, filt;
  cond_ev_t             ev;

  assign raw[LINE_SCL] = scl_i;
  assign raw[LINE_SDA] = sda_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .WIN        (FILT_WIN)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  i2c_cond_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_f_i (filt[LINE_SCL]),
    .sda_f_i (filt[LINE_SDA]),
    .ev_o    (ev),
    .active_o(bus_active_o)
  );

  i2c_cond_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .mode_irq_i(mode_irq_i),
    .start_ie_i(start_ie_i),
    .stop_ie_i (stop_ie_i),
    .irq_o     (irq_o)
  );

  assign start_o  = ev.start;
  assign rstart_o = ev.rstart;
  assign stop_o   = ev.stop;
  assign rx_clr_o = ev.start | ev.rstart;
endmodule

// File: rtl/i2c_cond_det_chk.sv
module i2c_cond_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_irq_i,
  input logic start_o,
  input logic rstart_o,
  input logic stop_o,
  input logic bus_active_o,
  input logic irq_o
);
  a_r11_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, rstart_o, stop_o}));
  a_r11_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  a_r11_stop_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
  a_r2_start_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> bus_active_o);
  a_r3_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !bus_active_o);
  a_r5_rstart_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstart_o |-> (bus_active_o && $past(bus_active_o)));
  a_r10_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(start_o || rstart_o || stop_o));
  a_r10_mode_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_irq_i) && $past(stop_o)) |-> irq_o);
endmodule

bind i2c_cond_det i2c_cond_det_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_irq_i  (mode_irq_i),
  .start_o     (start_o),
  .rstart_o    (rstart_o),
  .stop_o      (stop_o),
  .bus_active_o(bus_active_o),
  .irq_o       (irq_o)
);

// File: tb/i2c_cond_det_tb_top.sv
`timescale 1ns/1ps
module i2c_cond_det_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic mode_irq = 1'b0, start_ie = 1'b1, stop_ie = 1'b1;
  logic start_w, rstart_w, stop_w, rx_clr_w, active_w, irq_w;

  int n_chk = 0, n_fail = 0;
  int c_st = 0, c_rs = 0, c_sp = 0, c_irq = 0, c_rx = 0;

  always #2 clk = ~clk;

  i2c_cond_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .mode_irq_i(mode_irq), .start_ie_i(start_ie), .stop_ie_i(stop_ie),
    .start_o(start_w), .rstart_o(rstart_w), .stop_o(stop_w),
    .rx_clr_o(rx_clr_w), .bus_active_o(active_w), .irq_o(irq_w)
  );

  always @(negedge clk) if (rst_n) begin
    c_st  += int'(start_w);
    c_rs  += int'(rstart_w);
    c_sp  += int'(stop_w);
    c_irq += int'(irq_w);
    c_rx  += int'(rx_clr_w);
  end

  typedef struct packed {
    logic       scl;
    logic       sda;
    logic [1:0] st;
    logic [1:0] rs;
    logic [1:0] sp;
    logic       act;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0},
    '{1'b1, 1'b0, 2'd1, 2'd0, 2'd0, 1'b1},
    '{1'b0, 1'b0, 2'd1, 2'd0, 2'd0, 1'b1},
    '{1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 1'b1},
    '{1'b1, 1'b1, 2'd1, 2'd0, 2'd0, 1'b1},
    '{1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 1'b1},
    '{1'b0, 1'b0, 2'd1, 2'd0, 2'd0, 1'b1},
    '{1'b1, 1'b0, 2'd1, 2'd0, 2'd0, 1'b1},
    '{1'b1, 1'b1, 2'd1, 2'd0, 2'd1, 1'b0},
    '{1'b1, 1'b0, 2'd2, 2'd0, 2'd1, 1'b1},
    '{1'b1, 1'b1, 2'd2, 2'd0, 2'd1, 1'b1},
    '{1'b0, 1'b1, 2'd2, 2'd0, 2'd1, 1'b1},
    '{1'b1, 1'b1, 2'd2, 2'd0, 2'd1, 1'b1},
    '{1'b1, 1'b0, 2'd2, 2'd1, 2'd1, 1'b1},
    '{1'b0, 1'b0, 2'd2, 2'd1, 2'd1, 1'b1},
    '{1'b1, 1'b0, 2'd2, 2'd1, 2'd1, 1'b1},
    '{1'b1, 1'b1, 2'd2, 2'd1, 2'd2, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s_cl, input logic s_da, input int n);
    @(negedge clk);
    scl = s_cl;
    sda = s_da;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame();
    drive(1'b1, 1'b0, 12);
    drive(1'b0, 1'b0, 12);
    drive(1'b1, 1'b0, 12);
    drive(1'b1, 1'b1, 12);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int b_st, b_rs, b_sp, b_irq;
    repeat (3) @(negedge clk);
    chk("R1 start_o in reset", int'(start_w), 0);
    chk("R1 bus_active_o in reset", int'(active_w), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset",
        int'({start_w, rstart_w, stop_w, rx_clr_w, irq_w, active_w}), 0);
    repeat (12) @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R9 R10 (both enables on)
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].scl, VECS[i].sda, 12);
      chk($sformatf("R2 start count step %0d", i), c_st, int'(VECS[i].st));
      chk($sformatf("R5 rstart count step %0d", i), c_rs, int'(VECS[i].rs));
      chk($sformatf("R3 R4 stop count step %0d", i), c_sp, int'(VECS[i].sp));
      chk($sformatf("R3 bus_active step %0d", i), int'(active_w), int'(VECS[i].act));
      chk($sformatf("R9 rx_clr count step %0d", i), c_rx, int'(VECS[i].st) + int'(VECS[i].rs));
      chk($sformatf("R10 irq count step %0d", i), c_irq,
          int'(VECS[i].st) + int'(VECS[i].rs) + int'(VECS[i].sp));
    end

    // R7: one-clock SDA glitch on an idle bus
    b_st = c_st;
    @(negedge clk) sda = 1'b0;
    @(negedge clk) sda = 1'b1;
    repeat (12) @(negedge clk);
    chk("R7 glitch gives no start", c_st - b_st, 0);
    chk("R7 glitch leaves bus idle", int'(active_w), 0);

    // R6: simultaneous SCL/SDA edges on an active bus
    b_st = c_st; b_rs = c_rs; b_sp = c_sp;
    drive(1'b1, 1'b0, 12);
    drive(1'b0, 1'b0, 12);
    drive(1'b0, 1'b1, 12);
    drive(1'b1, 1'b1, 12);
    drive(1'b0, 1'b0, 12);
    chk("R6 joint fall gives no rstart", c_rs - b_rs, 0);
    drive(1'b1, 1'b1, 12);
    chk("R6 joint rise gives no stop", c_sp - b_sp, 0);
    chk("R6 bus stays active", int'(active_w), 1);
    drive(1'b0, 1'b0, 12);
    drive(1'b1, 1'b0, 12);
    drive(1'b1, 1'b1, 12);
    chk("R6 clean stop afterwards", c_sp - b_sp, 1);
    chk("R6 single start in sequence", c_st - b_st, 1);

    // R10: enable and mode masking
    b_irq = c_irq;
    start_ie = 1'b0; stop_ie = 1'b0; mode_irq = 1'b0;
    frame();
    chk("R10 all masked", c_irq - b_irq, 0);
    b_irq = c_irq;
    start_ie = 1'b1;
    frame();
    chk("R10 start only", c_irq - b_irq, 1);
    b_irq = c_irq; b_sp = c_sp;
    start_ie = 1'b0; mode_irq = 1'b1;
    frame();
    chk("R10 mode overrides enables", c_irq - b_irq, 2);
    chk("R3 stop counted in mode frame", c_sp - b_sp, 1);
    mode_irq = 1'b0; start_ie = 1'b1; stop_ie = 1'b1;

    // R8: reset released with SDA low
    b_st = c_st; b_sp = c_sp;
    @(negedge clk) rst_n = 1'b0;
    scl = 1'b1; sda = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R8 no start with SDA low at reset", c_st - b_st, 0);
    chk("R8 bus idle", int'(active_w), 0);
    drive(1'b1, 1'b1, 12);
    chk("R8 SDA release gives no stop", c_sp - b_sp, 0);
    chk("R8 SDA release gives no start", c_st - b_st, 0);
    drive(1'b1, 1'b0, 12);
    chk("R8 start after lines seen high", c_st - b_st, 1);
    drive(1'b0, 1'b0, 12);
    drive(1'b1, 1'b0, 12);
    drive(1'b1, 1'b1, 12);
    chk("R8 stop closes frame", c_sp - b_sp, 1);

    summary();
    $finish;
  end
endmodule